// File: doc/BRIEF.md
# Link-Level Flow Controller with Credit and Stop/Go Back-Pressure

This block is the sending end of a point-to-point link between two routers, paired with a small model of the receiving end. Each cycle it decides whether a flit on the chosen virtual channel may leave. Two back-pressure schemes are available, and the `mode_onoff` input picks one of them.

In credit mode the sender holds one counter per virtual channel. Each counter tracks the free slots in the matching receive buffer. A sent flit uses up one credit. The receive model pops buffered flits when its drain enable is high, and each pop sends one credit back over a return path. In stop/go mode the receive model raises a single stop level when any buffer fills to an upper threshold, and drops it again only when every buffer has fallen to a lower threshold. The sender stops while the stop level it sees is high.

The forward link and the return link are separate delay lines, each with its own cycle count. Because of this the round trip is explicit. A buffer that is too small for the credit round trip shows up as lost throughput. Headroom held back by the stop threshold shows up in the occupancy outputs.

Top module: `linkfc_top`

## Requirements
- R1: After reset every credit count equals BUF_DEPTH, every buffer occupancy is 0, `stop_out`, `credit_err` and `ovf_err` are 0, and `send_ok` is 1.
- R2: In credit mode (`mode_onoff`=0), `send_ok` is 1 exactly when the count of the VC on `send_vc` is non-zero. A send (`send_req` and `send_ok`) lowers that VC's count by one from the next cycle.
- R3: A drain pop in cycle u returns one credit that raises that VC's count from cycle u+CRD_LAT+1. A credit is reusable 6 cycles after its send (FWD_LAT=CRD_LAT=2), so with drain held on and continuous requests the default 8-entry buffer sustains one flit per cycle.
- R4: A send and a returning credit on the same VC in the same cycle leave that count unchanged. Under continuous traffic with drain on, the count therefore settles at BUF_DEPTH-5 (3 by default).
- R5: A flit sent in cycle t is counted in `buf_occ` from cycle t+FWD_LAT+1. A pop happens when the VC's drain enable is 1 and its occupancy is non-zero, and it lowers the occupancy from the next cycle. An arrival and a pop in the same cycle leave the occupancy unchanged.
- R6: The VCs are independent. Sends, credits and occupancy on one VC leave the other VCs' counts and occupancies unchanged. VC v's count sits at `credit_cnt[v*CW +: CW]` and its occupancy at `buf_occ[v*CW +: CW]`, with CW = clog2(BUF_DEPTH+1). Drain enable bit v belongs to VC v.
- R7: In stop/go mode (`mode_onoff`=1), `stop_out` rises in the cycle after any occupancy reaches OFF_TH, and `send_ok` falls CRD_LAT+1 cycles after that reach. No credits are returned and the counts hold.
- R8: `stop_out` falls in the cycle after every occupancy is at most ON_TH. It holds its value while occupancies lie between the thresholds.
- R9: Elaboration rejects ON_TH >= OFF_TH and OFF_TH+FWD_LAT+CRD_LAT+1 > BUF_DEPTH. With legal thresholds, continuous stop/go traffic fills a buffer to at most BUF_DEPTH and never overflows it.
- R10: A flit that arrives at a full VC buffer with no pop in that cycle is dropped, the occupancy stays at BUF_DEPTH, and `ovf_err` sets and stays set until reset.
- R11: A credit that would lift a count above BUF_DEPTH, or a send that would take it below zero, is ignored, and `credit_err` sets and stays set until reset. Legal traffic never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_onoff | input | 1 | 0 = credit counting, 1 = stop/go thresholds |
| send_req | input | 1 | Sender has a flit to send this cycle |
| send_vc | input | VCW | VC of the offered flit |
| drain_en | input | NUM_VC | Per-VC permission for the receive model to pop |
| send_ok | output | 1 | The flit on `send_vc` may leave this cycle |
| credit_cnt | output | NUM_VC*CW | Per-VC credit counts, packed |
| buf_occ | output | NUM_VC*CW | Per-VC receive buffer occupancy, packed |
| stop_out | output | 1 | Stop level driven by the receive model |
| credit_err | output | 1 | Sticky credit count overflow or underflow |
| ovf_err | output | 1 | Sticky receive buffer overflow |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a send and a returning credit on the same VC, which must leave the count unchanged. The second pair is a flit arriving at the receive buffer and a pop from it, which must leave the occupancy unchanged. Both are provoked by holding drain on with continuous requests on one VC: after the sixth cycle every cycle carries a send, a credit, an arrival and a pop together. The bench judges the result by sampling the count, which must hold at 3, and the occupancy, which must hold at 1, in mid-stream cycles. It also counts grants, which must be one per cycle. A separate directed run lets a credit arrive on a VC whose count is already full, to show that it saturates and flags an error instead of adding.

// File: rtl/linkfc_pkg.sv
package linkfc_pkg;

   typedef enum logic {
      FC_CREDIT = 1'b0,
      FC_ONOFF  = 1'b1
   } fc_mode_e;

   // bits needed to hold values 0..depth
   function automatic int cnt_bits(input int depth);
      return $clog2(depth + 1);
   endfunction

   // bits needed to index n channels (at least one)
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/linkfc_delay.sv
module linkfc_delay #(
   parameter int W   = 1,
   parameter int LAT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (LAT < 1) begin : g_bad_lat
      $error("linkfc_delay: LAT must be at least 1");
   end

   logic [LAT-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[LAT-1];

endmodule

// File: rtl/linkfc_credit_tx.sv
module linkfc_credit_tx
   import linkfc_pkg::*;
#(
   parameter int NUM_VC    = 2,
   parameter int BUF_DEPTH = 8,
   parameter int CNTW      = 4,
   parameter int VCW       = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode_onoff,
   input  logic                   send_req,
   input  logic [VCW-1:0]         send_vc,
   input  logic [NUM_VC-1:0]      crd_rtn,
   input  logic                   stop_rx,
   output logic                   send_ok,
   output logic                   send_fire,
   output logic [NUM_VC*CNTW-1:0] cnt_flat,
   output logic                   err
);

   localparam logic [CNTW-1:0] FULL = CNTW'(BUF_DEPTH);

   logic            is_onoff;
   logic [CNTW-1:0] sel_cnt;
   logic [NUM_VC-1:0] bad;

   assign is_onoff = (fc_mode_e'(mode_onoff) == FC_ONOFF);

   always_comb begin
      sel_cnt = '0;
      for (int v = 0; v < NUM_VC; v++) begin
         if (send_vc == VCW'(v)) sel_cnt = cnt_flat[v*CNTW +: CNTW];
      end
   end

   assign send_ok   = is_onoff ? !stop_rx : (sel_cnt != '0);
   assign send_fire = send_req && send_ok;

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic [CNTW-1:0] c_r;
      logic            take;

      assign take = send_fire && !is_onoff && (send_vc == VCW'(v));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_r <= FULL;
         end else if (take && !crd_rtn[v]) begin
            if (c_r != '0) c_r <= c_r - 1'b1;
         end else if (crd_rtn[v] && !take) begin
            if (c_r != FULL) c_r <= c_r + 1'b1;
         end
      end

      assign bad[v] = (take && !crd_rtn[v] && (c_r == '0)) ||
                      (crd_rtn[v] && !take && (c_r == FULL));
      assign cnt_flat[v*CNTW +: CNTW] = c_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else if (|bad) err <= 1'b1;
   end

endmodule

// File: rtl/linkfc_rx_stub.sv
module linkfc_rx_stub
   import linkfc_pkg::*;
#(
   parameter int NUM_VC    = 2,
   parameter int BUF_DEPTH = 8,
   parameter int CNTW      = 4,
   parameter int VCW       = 1,
   parameter int ON_TH     = 1,
   parameter int OFF_TH    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode_onoff,
   input  logic                   arr_vld,
   input  logic [VCW-1:0]         arr_vc,
   input  logic [NUM_VC-1:0]      drain_en,
   output logic [NUM_VC-1:0]      crd_out,
   output logic                   stop_q,
   output logic [NUM_VC*CNTW-1:0] occ_flat,
   output logic                   ovf_err
);

   localparam logic [CNTW-1:0] FULL = CNTW'(BUF_DEPTH);
   localparam logic [CNTW-1:0] HI   = CNTW'(OFF_TH);
   localparam logic [CNTW-1:0] LO   = CNTW'(ON_TH);

   logic              is_onoff;
   logic [NUM_VC-1:0] hi, lo, drop;

   assign is_onoff = (fc_mode_e'(mode_onoff) == FC_ONOFF);

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic [CNTW-1:0] occ_r;
      logic            arr, pop, full;

      assign arr  = arr_vld && (arr_vc == VCW'(v));
      assign pop  = drain_en[v] && (occ_r != '0);
      assign full = (occ_r == FULL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_r <= '0;
         end else if (arr && !pop && !full) begin
            occ_r <= occ_r + 1'b1;
         end else if (pop && !arr) begin
            occ_r <= occ_r - 1'b1;
         end
      end

      assign drop[v]    = arr && full && !pop;
      assign crd_out[v] = pop && !is_onoff;
      assign hi[v]      = (occ_r >= HI);
      assign lo[v]      = (occ_r <= LO);
      assign occ_flat[v*CNTW +: CNTW] = occ_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stop_q <= 1'b0;
      else if (!is_onoff) stop_q <= 1'b0;
      else if (|hi)      stop_q <= 1'b1;
      else if (&lo)      stop_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_err <= 1'b0;
      else if (|drop) ovf_err <= 1'b1;
   end

endmodule

// File: rtl/linkfc_top.sv
module linkfc_top
   import linkfc_pkg::*;
#(
   parameter int NUM_VC    = 2,
   parameter int BUF_DEPTH = 8,
   parameter int FWD_LAT   = 2,
   parameter int CRD_LAT   = 2,
   parameter int ON_TH     = 1,
   parameter int OFF_TH    = 3,
   localparam int VCW      = idx_bits(NUM_VC),
   localparam int CW       = cnt_bits(BUF_DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_onoff,
   input  logic                 send_req,
   input  logic [VCW-1:0]       send_vc,
   input  logic [NUM_VC-1:0]    drain_en,
   output logic                 send_ok,
   output logic [NUM_VC*CW-1:0] credit_cnt,
   output logic [NUM_VC*CW-1:0] buf_occ,
   output logic                 stop_out,
   output logic                 credit_err,
   output logic                 ovf_err
);

   // R9: elaboration-time parameter checks
   if (NUM_VC < 1) begin : g_chk_vc
      $error("linkfc_top: NUM_VC must be at least 1");
   end
   if (BUF_DEPTH < 1) begin : g_chk_depth
      $error("linkfc_top: BUF_DEPTH must be at least 1");
   end
   if (ON_TH >= OFF_TH) begin : g_chk_hyst
      $error("linkfc_top: ON_TH must sit below OFF_TH");
   end
   if (OFF_TH + FWD_LAT + CRD_LAT + 1 > BUF_DEPTH) begin : g_chk_room
      $error("linkfc_top: OFF_TH leaves no room for flits in flight");
   end

   logic              fire;
   logic [VCW:0]      fwd_in, fwd_out;
   logic [NUM_VC-1:0] crd_gen, crd_back;
   logic              stop_back;

   linkfc_credit_tx #(
      .NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH), .CNTW(CW), .VCW(VCW)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .mode_onoff(mode_onoff),
      .send_req(send_req), .send_vc(send_vc),
      .crd_rtn(crd_back), .stop_rx(stop_back),
      .send_ok(send_ok), .send_fire(fire),
      .cnt_flat(credit_cnt), .err(credit_err)
   );

   assign fwd_in = {fire, send_vc};

   linkfc_delay #(.W(VCW+1), .LAT(FWD_LAT)) u_fwd (
      .clk(clk), .rst_n(rst_n), .d(fwd_in), .q(fwd_out)
   );

   linkfc_rx_stub #(
      .NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH), .CNTW(CW), .VCW(VCW),
      .ON_TH(ON_TH), .OFF_TH(OFF_TH)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .mode_onoff(mode_onoff),
      .arr_vld(fwd_out[VCW]), .arr_vc(fwd_out[VCW-1:0]),
      .drain_en(drain_en), .crd_out(crd_gen), .stop_q(stop_out),
      .occ_flat(buf_occ), .ovf_err(ovf_err)
   );

   linkfc_delay #(.W(NUM_VC), .LAT(CRD_LAT)) u_crd (
      .clk(clk), .rst_n(rst_n), .d(crd_gen), .q(crd_back)
   );

   linkfc_delay #(.W(1), .LAT(CRD_LAT)) u_stop (
      .clk(clk), .rst_n(rst_n), .d(stop_out), .q(stop_back)
   );

endmodule

// File: rtl/linkfc_chk.sv
module linkfc_chk #(
   parameter int NUM_VC    = 2,
   parameter int BUF_DEPTH = 8,
   parameter int ON_TH     = 1,
   parameter int VCW       = 1,
   parameter int CW        = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mode_onoff,
   input logic                 send_req,
   input logic [VCW-1:0]       send_vc,
   input logic                 send_ok,
   input logic [NUM_VC*CW-1:0] credit_cnt,
   input logic [NUM_VC*CW-1:0] buf_occ,
   input logic                 stop_out,
   input logic                 credit_err,
   input logic                 ovf_err
);

   logic above_on;

   always_comb begin
      above_on = 1'b0;
      for (int v = 0; v < NUM_VC; v++) begin
         if (int'(buf_occ[v*CW +: CW]) > ON_TH) above_on = 1'b1;
      end
   end

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      // R2: no grant on an exhausted VC in credit mode
      a_r2_no_send_empty: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode_onoff && send_req && (send_vc == VCW'(v)) &&
          (credit_cnt[v*CW +: CW] == '0)) |-> !send_ok);

      // R11: count stays inside 0..BUF_DEPTH
      a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
         int'(credit_cnt[v*CW +: CW]) <= BUF_DEPTH);

      // R10: occupancy never exceeds the buffer
      a_r10_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
         int'(buf_occ[v*CW +: CW]) <= BUF_DEPTH);
   end

   // R8: stop holds while some buffer is above the low mark
   a_r8_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_onoff && stop_out && above_on) |=> stop_out);

   // R10: overflow flag is sticky
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

   // R11: credit error flag is sticky
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      credit_err |=> credit_err);

endmodule

bind linkfc_top linkfc_chk #(
   .NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH), .ON_TH(ON_TH), .VCW(VCW), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_onoff(mode_onoff),
   .send_req(send_req), .send_vc(send_vc), .send_ok(send_ok),
   .credit_cnt(credit_cnt), .buf_occ(buf_occ), .stop_out(stop_out),
   .credit_err(credit_err), .ovf_err(ovf_err)
);

// File: tb/linkfc_top_test.sv
`timescale 1ns/1ps
module linkfc_top_test;

   localparam int NV = 2;
   localparam int DP = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_onoff = 1'b0;
   logic          send_req = 1'b0;
   logic [0:0]    send_vc = '0;
   logic [NV-1:0] drain_en = '0;
   logic          send_ok;
   logic [NV*CW-1:0] credit_cnt, buf_occ;
   logic          stop_out, credit_err, ovf_err;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   linkfc_top #(.NUM_VC(NV), .BUF_DEPTH(DP), .FWD_LAT(2), .CRD_LAT(2),
                .ON_TH(1), .OFF_TH(3)) uut (
      .clk(clk), .rst_n(rst_n), .mode_onoff(mode_onoff),
      .send_req(send_req), .send_vc(send_vc), .drain_en(drain_en),
      .send_ok(send_ok), .credit_cnt(credit_cnt), .buf_occ(buf_occ),
      .stop_out(stop_out), .credit_err(credit_err), .ovf_err(ovf_err)
   );

   function automatic int cnt_of(input int v);
      return int'(credit_cnt[v*CW +: CW]);
   endfunction

   function automatic int occ_of(input int v);
      return int'(buf_occ[v*CW +: CW]);
   endfunction

   task automatic chk(input string rq, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(posedge clk); #1;
   endtask

   task automatic do_reset(input logic m);
      rst_n = 1'b0; mode_onoff = m; send_req = 1'b0; send_vc = '0; drain_en = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // row: {req, vc, drain[1:0], ok, cnt0[3:0], cnt1[3:0]}  (credit mode, from reset)
   localparam int NROW = 8;
   localparam logic [12:0] VEC [NROW] = '{
      {1'b1, 1'b0, 2'b00, 1'b1, 4'd8, 4'd8},
      {1'b1, 1'b1, 2'b00, 1'b1, 4'd7, 4'd8},
      {1'b1, 1'b0, 2'b00, 1'b1, 4'd7, 4'd7},
      {1'b0, 1'b0, 2'b01, 1'b1, 4'd6, 4'd7},
      {1'b0, 1'b0, 2'b00, 1'b1, 4'd6, 4'd7},
      {1'b0, 1'b0, 2'b00, 1'b1, 4'd6, 4'd7},
      {1'b1, 1'b0, 2'b00, 1'b1, 4'd7, 4'd7},
      {1'b0, 1'b0, 2'b00, 1'b1, 4'd6, 4'd7}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int grants;
      int prev_occ;

      // ---------------- R1 reset state
      do_reset(1'b0);
      @(negedge clk);
      chk("R1 cnt0", cnt_of(0), DP);
      chk("R1 cnt1", cnt_of(1), DP);
      chk("R1 occ0", occ_of(0), 0);
      chk("R1 occ1", occ_of(1), 0);
      chk("R1 stop_out", int'(stop_out), 0);
      chk("R1 credit_err", int'(credit_err), 0);
      chk("R1 ovf_err", int'(ovf_err), 0);
      chk("R1 send_ok", int'(send_ok), 1);

      // ---------------- vector table: R2 decrement, R3 credit return, R6 VCs apart
      do_reset(1'b0);
      for (int r = 0; r < NROW; r++) begin
         send_req = VEC[r][12];
         send_vc  = VEC[r][11];
         drain_en = VEC[r][10:9];
         @(negedge clk);
         chk($sformatf("R2 row%0d send_ok", r), int'(send_ok), int'(VEC[r][8]));
         chk($sformatf("R3 row%0d cnt0", r), cnt_of(0), int'(VEC[r][7:4]));
         chk($sformatf("R6 row%0d cnt1", r), cnt_of(1), int'(VEC[r][3:0]));
         next_cycle();
      end
      send_req = 1'b0; drain_en = '0;

      // ---------------- R5 forward latency and pop
      do_reset(1'b0);
      for (int c = 0; c < 5; c++) begin
         send_req = (c == 0);
         send_vc  = '0;
         drain_en = (c == 3) ? 2'b01 : 2'b00;
         @(negedge clk);
         if (c == 2) chk("R5 occ0 before arrival", occ_of(0), 0);
         if (c == 3) chk("R5 occ0 after arrival", occ_of(0), 1);
         if (c == 4) chk("R5 occ0 after pop", occ_of(0), 0);
         next_cycle();
      end
      send_req = 1'b0; drain_en = '0;

      // ---------------- R3/R4/R5 streaming with drain on
      do_reset(1'b0);
      grants = 0;
      send_req = 1'b1; send_vc = '0; drain_en = 2'b11;
      for (int c = 0; c < 24; c++) begin
         @(negedge clk);
         if (send_ok) grants++;
         if (c == 6)  chk("R4 cnt0 steady c6", cnt_of(0), DP - 5);
         if (c == 20) chk("R4 cnt0 steady c20", cnt_of(0), DP - 5);
         if (c == 15) chk("R5 occ0 arrival+pop", occ_of(0), 1);
         next_cycle();
      end
      chk("R3 full-rate grants", grants, 24);
      send_req = 1'b0;
      repeat (12) next_cycle();
      @(negedge clk);
      chk("R3 cnt0 refilled", cnt_of(0), DP);
      chk("R11 credit_err legal", int'(credit_err), 0);
      next_cycle();
      drain_en = '0;

      // ---------------- R2/R6 exhaust VC1 with no drain
      do_reset(1'b0);
      grants = 0;
      send_req = 1'b1; send_vc = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (send_ok) grants++;
         if (c == 9) chk("R2 send_ok at zero", int'(send_ok), 0);
         next_cycle();
      end
      send_req = 1'b0;
      chk("R2 grants to depth", grants, DP);
      repeat (4) next_cycle();
      @(negedge clk);
      chk("R2 cnt1 empty", cnt_of(1), 0);
      chk("R6 cnt0 untouched", cnt_of(0), DP);
      chk("R6 occ1 full", occ_of(1), DP);
      chk("R6 occ0 untouched", occ_of(0), 0);
      next_cycle();
      drain_en = 2'b10;
      next_cycle();
      drain_en = 2'b00;
      @(negedge clk);
      chk("R5 occ1 after one pop", occ_of(1), DP - 1);
      next_cycle();

      // ---------------- R7/R9 stop/go fill
      do_reset(1'b1);
      grants = 0;
      send_req = 1'b1; send_vc = '0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (send_ok) grants++;
         if (c == 5) chk("R7 stop_out low c5", int'(stop_out), 0);
         if (c == 6) chk("R7 stop_out high c6", int'(stop_out), 1);
         if (c == 7) chk("R7 send_ok c7", int'(send_ok), 1);
         if (c == 8) chk("R7 send_ok c8", int'(send_ok), 0);
         next_cycle();
      end
      send_req = 1'b0;
      @(negedge clk);
      chk("R9 grants", grants, 8);
      chk("R9 occ0 at depth", occ_of(0), DP);
      chk("R9 ovf_err", int'(ovf_err), 0);
      chk("R7 cnt0 held", cnt_of(0), DP);
      next_cycle();

      // ---------------- R8 hysteresis while draining
      drain_en = 2'b01;
      prev_occ = -1;
      for (int c = 0; c < 14; c++) begin
         @(negedge clk);
         if (occ_of(0) == 2) chk("R8 hold between marks", int'(stop_out), 1);
         if (occ_of(0) == 1) chk("R8 hold at low mark", int'(stop_out), 1);
         if (prev_occ == 1)  chk("R8 release", int'(stop_out), 0);
         prev_occ = occ_of(0);
         next_cycle();
      end
      drain_en = '0;

      // ---------------- R10/R11 mode switch on a full buffer
      do_reset(1'b1);
      send_req = 1'b1; send_vc = '0;
      repeat (20) next_cycle();
      send_req = 1'b0; mode_onoff = 1'b0;
      next_cycle();
      send_req = 1'b1;
      @(negedge clk);
      chk("R2 send_ok after switch", int'(send_ok), 1);
      next_cycle();
      send_req = 1'b0;
      repeat (2) next_cycle();
      @(negedge clk);
      chk("R10 ovf_err set", int'(ovf_err), 1);
      chk("R10 occ0 saturated", occ_of(0), DP);
      chk("R10 cnt0 after send", cnt_of(0), DP - 1);
      next_cycle();
      drain_en = 2'b01;
      repeat (15) next_cycle();
      @(negedge clk);
      chk("R11 credit_err set", int'(credit_err), 1);
      chk("R11 cnt0 saturated", cnt_of(0), DP);
      chk("R10 ovf_err sticky", int'(ovf_err), 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule